// File: doc/BRIEF.md
# Endian-Configurable Data Memory Access Unit

This unit connects the load/store stage of a processor to a private, byte-addressed data RAM. It serves byte, halfword and word accesses in both directions. A mode pin selects, per request, whether the most significant byte of a multi-byte value is placed at the lowest address (big-endian) or the least significant byte is (little-endian).

Each request is checked before the RAM is touched. An address at or beyond the configured memory size gives an out-of-range fault. An access that is not on a boundary of its own width gives a misalignment fault. The range fault wins when both apply. A faulting write changes nothing, and a faulting read returns zero.

Requests use a valid/ready handshake. `req_ready` is low during reset and then stays high, so the unit never applies back-pressure and accepts one request every cycle. The response is a plain one-cycle `rsp_done` pulse that cannot be stalled, so the core must take it in the cycle it appears. The RAM is held inside the unit as four byte-wide banks with synchronous reads.

Top module: `dmem_port`

## Requirements
- R1: Any access with `req_addr` >= MEM_BYTES returns fault code 2'b01 and modifies no byte of memory, including the byte that the truncated row index would select.
- R2: A word access (size 2'b10, or the reserved code 2'b11, which is treated as a word) with `req_addr[1:0]` != 0, or a halfword access (size 2'b01) with `req_addr[0]` = 1, returns fault code 2'b10 and modifies no memory.
- R3: A byte access (size 2'b00) that is in range always returns fault code 2'b00.
- R4: When an access is both out of range and misaligned, the fault code is 2'b01.
- R5: With `be_mode` = 1, the most significant byte of a halfword or word is stored at and read from the lowest address of the access.
- R6: With `be_mode` = 0, the least significant byte of a halfword or word is stored at and read from the lowest address of the access.
- R7: A read that faults returns `rsp_rdata` = 0. Any write response also carries `rsp_rdata` = 0.
- R8: Byte and halfword reads return their value zero-extended to 32 bits.
- R9: A request accepted at a clock edge (`req_valid` and `req_ready` both high) gives `rsp_done` = 1, with a valid `rsp_fault`, for exactly the following cycle. `rsp_done` is 0 when the previous edge accepted no request. `req_ready` is 1 whenever reset is not asserted.
- R10: While reset is asserted and directly after it, `rsp_done`, `rsp_fault` and `rsp_rdata` are all 0.
- R11: A write changes only the bytes inside its own address span. Other bytes in the same 32-bit word keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Unit accepts a request (high whenever out of reset) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| req_wdata | input | 32 | Store value, right-aligned |
| be_mode | input | 1 | 1 = big-endian, 0 = little-endian |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load value, zero-extended; 0 on faults and stores |
| rsp_fault | output | 2 | 00 none, 01 out of range, 10 misaligned |

## Verification
The hardest case to reach from the ports is an out-of-range store whose truncated row index would land on a live RAM location. It can only be seen by reading that aliased location back afterwards. The stimulus stores to addresses just above the memory size and then loads from the low offsets they would alias to. The same is done for misaligned stores, which are followed by a load of the surrounding aligned word. Random traffic mixes both byte orders, all four size codes and addresses inside the memory, just past its end and far above it. Every response is compared against a byte-array model in the bench.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_RANGE = 2'd1,
    FLT_ALIGN = 2'd2
  } fault_e;

  // number of bytes covered by a size code; the reserved code acts as a word
  function automatic int unsigned acc_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // significance of the j-th byte (counted from the lowest address) of an n-byte value
  function automatic int unsigned sig_index(input int unsigned j, input int unsigned n,
                                            input logic big);
    return big ? (n - 1 - j) : j;
  endfunction

endpackage

// File: rtl/dmem_check.sv
module dmem_check
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MEM_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [1:0]        fault
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_BYTES);

  logic in_range;
  logic misalign;

  always_comb begin
    in_range = (addr < LIMIT);
    misalign = 1'b0;
    if (size == ACC_HALF && addr[0])
      misalign = 1'b1;
    if (size[1] && addr[1:0] != 2'b00)
      misalign = 1'b1;
    // range first, alignment second
    if (!in_range)
      fault = FLT_RANGE;
    else if (misalign)
      fault = FLT_ALIGN;
    else
      fault = FLT_NONE;
  end

endmodule

// File: rtl/dmem_wr_steer.sv
module dmem_wr_steer
  import dmem_pkg::*;
(
  input  logic [1:0]             lo,
  input  logic [1:0]             size,
  input  logic                   big,
  input  logic [31:0]            wdata,
  output logic [LANES-1:0]       hit,
  output logic [LANES-1:0][7:0]  lane_wd
);

  int unsigned n;
  int unsigned base;

  always_comb begin
    n    = acc_bytes(size);
    base = {30'd0, lo} & ~(n - 1);
    for (int unsigned k = 0; k < LANES; k++) begin
      hit[k]     = 1'b0;
      lane_wd[k] = 8'h00;
      if (k >= base && k < base + n) begin
        hit[k]     = 1'b1;
        lane_wd[k] = wdata[8*sig_index(k - base, n, big) +: 8];
      end
    end
  end

endmodule

// File: rtl/dmem_rd_gather.sv
module dmem_rd_gather
  import dmem_pkg::*;
(
  input  logic [1:0]             lo,
  input  logic [1:0]             size,
  input  logic                   big,
  input  logic [LANES-1:0][7:0]  lane_rd,
  output logic [31:0]            rdata
);

  int unsigned n;
  int unsigned base;

  always_comb begin
    n     = acc_bytes(size);
    base  = {30'd0, lo} & ~(n - 1);
    rdata = '0;
    for (int unsigned i = 0; i < LANES; i++) begin
      if (i < n)
        rdata[8*i +: 8] = lane_rd[2'(base + sig_index(i, n, big))];
    end
  end

endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
  parameter int ROWS  = 256,
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);

  logic [7:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (we)
      store[row] <= wbyte;
    if (re)
      rbyte <= store[row];
  end

endmodule

// File: rtl/dmem_port.sv
module dmem_port
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              be_mode,
  output logic              rsp_done,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        rsp_fault
);

  localparam int ROWS  = MEM_BYTES / LANES;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic                  accept;
  logic [1:0]            fault_now;
  logic [LANES-1:0]      lane_hit;
  logic [LANES-1:0][7:0] lane_wd;
  logic [LANES-1:0][7:0] lane_rd;
  logic [LANES-1:0]      lane_we;
  logic                  rd_go;
  logic [ROW_W-1:0]      row;
  logic [31:0]           gathered;

  logic       done_q;
  logic [1:0] fault_q;
  logic       wr_q;
  logic [1:0] lo_q;
  logic [1:0] size_q;
  logic       big_q;

  assign accept = req_valid && req_ready;
  assign row    = req_addr[ROW_W+1:2];

  dmem_check #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_check (
    .addr  (req_addr),
    .size  (req_size),
    .fault (fault_now)
  );

  dmem_wr_steer u_steer (
    .lo      (req_addr[1:0]),
    .size    (req_size),
    .big     (be_mode),
    .wdata   (req_wdata),
    .hit     (lane_hit),
    .lane_wd (lane_wd)
  );

  assign rd_go = accept && !req_write && (fault_now == FLT_NONE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = accept && req_write && (fault_now == FLT_NONE) && lane_hit[g];
    dmem_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .we    (lane_we[g]),
      .re    (rd_go),
      .row   (row),
      .wbyte (lane_wd[g]),
      .rbyte (lane_rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      done_q    <= 1'b0;
      fault_q   <= FLT_NONE;
      wr_q      <= 1'b0;
      lo_q      <= 2'b00;
      size_q    <= ACC_BYTE;
      big_q     <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      done_q    <= accept;
      if (accept) begin
        fault_q <= fault_now;
        wr_q    <= req_write;
        lo_q    <= req_addr[1:0];
        size_q  <= req_size;
        big_q   <= be_mode;
      end
    end
  end

  dmem_rd_gather u_gather (
    .lo      (lo_q),
    .size    (size_q),
    .big     (big_q),
    .lane_rd (lane_rd),
    .rdata   (gathered)
  );

  assign rsp_done  = done_q;
  assign rsp_fault = done_q ? fault_q : FLT_NONE;
  assign rsp_rdata = (done_q && !wr_q && fault_q == FLT_NONE) ? gathered : 32'd0;

  // ---------------------------------------------------------------- checks
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_done); // R9

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_done); // R9

  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault != FLT_NONE) |-> rsp_rdata == 32'd0); // R7

  AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && req_size == ACC_BYTE) |=> rsp_rdata[31:8] == 24'd0); // R8

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |-> req_addr < ADDR_W'(MEM_BYTES)); // R1

  AST_RANGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_addr >= ADDR_W'(MEM_BYTES)) |=> rsp_fault == FLT_RANGE); // R4

  AST_BYTE_NEVER_ALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_size == ACC_BYTE) |=> rsp_fault != FLT_ALIGN); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> (rsp_fault == FLT_NONE && rsp_rdata == 32'd0)); // R10

endmodule

// File: tb/dmem_port_tb_top.sv
`timescale 1ns/1ps
module dmem_port_tb_top;

  localparam int MEMB = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        be_mode = 1'b0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] ref_mem [MEMB];

  always #4 clk = ~clk;

  dmem_port #(.ADDR_W(32), .MEM_BYTES(MEMB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .be_mode(be_mode), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault)
  );

  function automatic int unsigned nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [1:0] exp_fault(input logic [31:0] a, input logic [1:0] sz);
    if (a >= MEMB) return 2'b01;
    if (sz == 2'd1 && a[0]) return 2'b10;
    if (sz[1] && a[1:0] != 2'b00) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [1:0] sz,
                                           input logic big);
    logic [31:0] v;
    int unsigned n;
    n = nbytes(sz);
    v = '0;
    for (int unsigned i = 0; i < n; i++)
      v[8*i +: 8] = ref_mem[a + (big ? (n - 1 - i) : i)];
    return v;
  endfunction

  task automatic model_write(input logic [31:0] a, input logic [1:0] sz, input logic big,
                             input logic [31:0] wd);
    int unsigned n;
    n = nbytes(sz);
    for (int unsigned j = 0; j < n; j++)
      ref_mem[a + j] = wd[8*(big ? (n - 1 - j) : j) +: 8];
  endtask

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // call at a negedge; returns at the next negedge with the request withdrawn
  task automatic access(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic big, input logic [31:0] wd, input string tag);
    logic [1:0]  ef;
    logic [31:0] er;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    be_mode = big; req_wdata = wd;
    ef = exp_fault(a, sz);
    er = (wr || ef != 2'b00) ? 32'd0 : exp_read(a, sz, big);
    @(negedge clk);
    check_eq({tag, " R9 done"}, {31'd0, rsp_done}, 32'd1);
    check_eq({tag, " fault"}, {30'd0, rsp_fault}, {30'd0, ef});
    check_eq({tag, " data"}, rsp_rdata, er);
    if (wr && ef == 2'b00) model_write(a, sz, big, wd);
    req_valid = 1'b0;
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    @(negedge clk);
    check_eq("R9 no done when idle", {31'd0, rsp_done}, 32'd0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    check_eq("R10 reset done", {31'd0, rsp_done}, 32'd0);
    check_eq("R10 reset fault", {30'd0, rsp_fault}, 32'd0);
    check_eq("R10 reset data", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9 ready after reset", {31'd0, req_ready}, 32'd1);
    check_eq("R10 idle after reset", {31'd0, rsp_done}, 32'd0);

    // fill memory so the model and the RAM agree
    for (int w = 0; w < MEMB / 4; w++)
      access(1'b1, 32'(w * 4), 2'd2, 1'b0, $urandom, "R6 fill");
    idle_check();

    // byte order
    access(1'b1, 32'h10, 2'd2, 1'b1, 32'h11223344, "R5 word store");
    access(1'b0, 32'h10, 2'd0, 1'b1, 0, "R5 msb at low addr");
    check_eq("R5 byte value", {24'd0, ref_mem[16]}, 32'h11);
    access(1'b0, 32'h10, 2'd2, 1'b0, 0, "R6 word swap");
    access(1'b0, 32'h12, 2'd1, 1'b1, 0, "R8 half zero-ext");
    access(1'b1, 32'h20, 2'd1, 1'b0, 32'hFFFF_BEEF, "R6 half store");
    access(1'b0, 32'h20, 2'd0, 1'b0, 0, "R6 lsb at low addr");
    access(1'b0, 32'h20, 2'd1, 1'b1, 0, "R8 half BE read");
    // partial write
    access(1'b1, 32'h21, 2'd0, 1'b1, 32'h1234_56AA, "R11 byte store");
    access(1'b0, 32'h20, 2'd2, 1'b1, 0, "R11 neighbours kept");
    // misalignment
    access(1'b1, 32'h31, 2'd2, 1'b0, 32'hDEAD_BEEF, "R2 word misaligned");
    access(1'b0, 32'h30, 2'd2, 1'b0, 0, "R2 no update");
    access(1'b1, 32'h33, 2'd1, 1'b1, 32'h0000_5555, "R2 half misaligned");
    access(1'b0, 32'h33, 2'd1, 1'b0, 0, "R7 faulted read zero");
    access(1'b0, 32'h36, 2'd3, 1'b0, 0, "R2 reserved size as word");
    access(1'b0, 32'h33, 2'd0, 1'b0, 0, "R3 byte any offset");
    access(1'b1, 32'h3FF, 2'd0, 1'b1, 32'h77, "R3 last byte");
    // range
    access(1'b1, MEMB, 2'd2, 1'b0, 32'hCAFE_F00D, "R1 store past end");
    access(1'b0, 32'h0, 2'd2, 1'b0, 0, "R1 alias untouched");
    access(1'b1, MEMB + 6, 2'd1, 1'b1, 32'h0000_9999, "R1 half past end");
    access(1'b0, 32'h4, 2'd2, 1'b0, 0, "R1 alias untouched 2");
    access(1'b0, MEMB + 1, 2'd2, 1'b0, 0, "R4 range beats align");
    access(1'b0, 32'hFFFF_FFFF, 2'd1, 1'b1, 0, "R4 top address");
    idle_check();

    // random traffic, back to back with occasional idle cycles
    for (int t = 0; t < 3000; t++) begin
      logic [31:0] a;
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r < 8)       a = $urandom_range(0, MEMB - 1);
      else if (r == 8) a = MEMB + $urandom_range(0, 63);
      else             a = $urandom;
      access(1'($urandom), a, 2'($urandom), 1'($urandom), $urandom, "R5 R6 R7 random");
      if ($urandom_range(0, 15) == 0) idle_check();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule